// File: doc/BRIEF.md
# Hierarchical DMA Transfer Sequencer

This block is one channel of a memory-to-memory copy engine. A copy is organised as three nested units: a transaction is split into blocks, and each block is split into fragments. Each step moves one element. The element is read from the source address and written to the destination address a cycle later. Both addresses then advance by their own step.

Software fills in the channel settings and pulses `start`. The 2-bit request mode decides how far a single trigger carries the copy: one fragment, one block, or the whole transaction. Between triggers the channel waits with its position kept. Each further trigger resumes from the point where the copy stopped. A done pulse is raised for every fragment, block and transaction boundary the copy crosses. The current destination address can be observed at any time to follow progress. An invalid setting is refused at the trigger with an error pulse, and no memory access is made.

Top module: `hier_dma_seq`

## Requirements
- R1: After reset no memory read or write is requested, no done or error pulse is raised, and the live destination address is 0.
- R2: Every element is one read of the source address followed by one write of the same data to the destination address in the next cycle. Width code 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. The size outputs carry the width code, and the write data keeps only the bytes of that width.
- R3: A full address is 36 bits: 4 top bits taken from their own input, placed above the 32-bit low address. After each element the source address grows by bits 15:0 of the step word and the destination address grows by bits 31:16.
- R4: When the hold enable is set, hold select 0 keeps the source address constant and hold select 1 keeps the destination address constant for the whole copy.
- R5: Lengths count bytes. A fragment ends when its bytes reach the fragment length, or when its block ends. A block ends when its bytes reach the block length, or when the transaction ends. The transaction ends at the transaction length. Each end gives a one-cycle pulse in the cycle after the write that reaches it, and the count of every lower unit restarts.
- R6: Request mode 0 stops the copy at the next fragment end, mode 1 at the next block end, and mode 2 at the transaction end.
- R7: While stopped between units, the channel makes no access and holds its addresses. A `start` in that state resumes with the settings taken at the first trigger. A `start` while elements are moving has no effect.
- R8: A trigger from idle with request mode 3, width code 3, unequal source and destination widths, any zero length, or any length that is not a multiple of the element width gives a one-cycle error pulse in the next cycle, and no read or write follows.
- R9: The live destination address output shows the destination register. It changes only at the end of a write or at a trigger from idle.
- R10: After a transaction ends the channel is idle again. The next trigger loads fresh settings and the new destination base is visible in the cycle after that trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger pulse |
| src_lo | input | 32 | Source address, low 32 bits |
| src_top | input | 4 | Source address, top 4 bits |
| dst_lo | input | 32 | Destination address, low 32 bits |
| dst_top | input | 4 | Destination address, top 4 bits |
| src_width | input | 2 | Source element width code |
| dst_width | input | 2 | Destination element width code |
| step_word | input | 32 | Destination step in 31:16, source step in 15:0 |
| hold_en | input | 1 | Keep one address constant |
| hold_sel | input | 1 | 0 holds source, 1 holds destination |
| frag_len | input | 17 | Fragment length in bytes |
| blk_len | input | 17 | Block length in bytes |
| xact_len | input | 28 | Transaction length in bytes |
| req_mode | input | 2 | Stop unit: 0 fragment, 1 block, 2 transaction, 3 refused |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | 36 | Read address |
| mem_rd_size | output | 2 | Read width code |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Write request |
| mem_wr_addr | output | 36 | Write address |
| mem_wr_size | output | 2 | Write width code |
| mem_wr_data | output | 32 | Write data |
| frag_done | output | 1 | Fragment end pulse |
| blk_done | output | 1 | Block end pulse |
| xact_done | output | 1 | Transaction end pulse |
| cfg_err | output | 1 | Refused-setting pulse |
| dst_now | output | 36 | Live destination address |

## Verification
The copy is run with byte elements and even fragments, and with word elements where the block length is not a multiple of the fragment length. The second case shows whether a short last fragment closes at the block end. Two-byte copies in fragment mode and in block mode, each with several triggers, show where the copy parks and whether a resume keeps its place. Pulse counts and the destination address are compared after each trigger. Runs with a held source, a held destination, unequal steps and a non-zero top nibble separate the two address paths. The five refused settings are each shown to raise the error without any access.

// File: rtl/hds_pkg.sv
package hds_pkg;

  localparam int NLVL = 3;

  typedef enum logic [1:0] {
    RQ_FRAG  = 2'd0,
    RQ_BLOCK = 2'd1,
    RQ_XACT  = 2'd2,
    RQ_CHAIN = 2'd3
  } rq_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_PARK = 2'd3
  } seq_state_t;

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd0:    elem_bytes = 3'd1;
      2'd1:    elem_bytes = 3'd2;
      2'd2:    elem_bytes = 3'd4;
      default: elem_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/hds_cfg_check.sv
module hds_cfg_check import hds_pkg::*; #(
  parameter int CNT_W = 28
) (
  input  logic [1:0]                 mode,
  input  logic [1:0]                 src_w,
  input  logic [1:0]                 dst_w,
  input  logic [NLVL-1:0][CNT_W-1:0] lens,
  output logic                       bad
);

  logic [CNT_W-1:0] align_mask;
  logic             len_bad;

  assign align_mask = CNT_W'(elem_bytes(src_w)) - CNT_W'(1);

  always_comb begin
    len_bad = 1'b0;
    for (int i = 0; i < NLVL; i++) begin
      if (lens[i] == '0)                len_bad = 1'b1;
      if ((lens[i] & align_mask) != '0) len_bad = 1'b1;
    end
  end

  assign bad = (mode == RQ_CHAIN) | (src_w == 2'd3) | (src_w != dst_w) | len_bad;

endmodule

// File: rtl/hds_level_ctr.sv
module hds_level_ctr #(
  parameter int CNT_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [2:0]       inc,
  input  logic [CNT_W-1:0] len,
  input  logic             end_in,
  output logic             end_out
);

  logic [CNT_W-1:0] cnt_q, cnt_d, sum;
  logic             hit;

  assign sum     = cnt_q + CNT_W'(inc);
  assign hit     = (sum >= len);
  assign end_out = hit | end_in;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = end_out ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr | adv)  cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hds_addr_reg.sv
module hds_addr_reg #(
  parameter int ADDR_W = 36,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              adv,
  input  logic              hold,
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              upd;

  assign upd = load | (adv & ~hold);

  always_comb begin
    addr_d = addr_q;
    if (load)     addr_d = base;
    else if (upd) addr_d = addr_q + ADDR_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (upd) addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/hier_dma_seq.sv
module hier_dma_seq import hds_pkg::*; #(
  parameter int ADDR_LO_W  = 32,
  parameter int ADDR_HI_W  = 4,
  parameter int STEP_W     = 16,
  parameter int DATA_W     = 32,
  parameter int FRAG_LEN_W = 17,
  parameter int BLK_LEN_W  = 17,
  parameter int XACT_LEN_W = 28,
  localparam int ADDR_W    = ADDR_LO_W + ADDR_HI_W,
  localparam int SWORD_W   = 2 * STEP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [ADDR_LO_W-1:0]  src_lo,
  input  logic [ADDR_HI_W-1:0]  src_top,
  input  logic [ADDR_LO_W-1:0]  dst_lo,
  input  logic [ADDR_HI_W-1:0]  dst_top,
  input  logic [1:0]            src_width,
  input  logic [1:0]            dst_width,
  input  logic [SWORD_W-1:0]    step_word,
  input  logic                  hold_en,
  input  logic                  hold_sel,
  input  logic [FRAG_LEN_W-1:0] frag_len,
  input  logic [BLK_LEN_W-1:0]  blk_len,
  input  logic [XACT_LEN_W-1:0] xact_len,
  input  logic [1:0]            req_mode,
  output logic                  mem_rd_en,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  output logic [1:0]            mem_rd_size,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic                  mem_wr_en,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  output logic [1:0]            mem_wr_size,
  output logic [DATA_W-1:0]     mem_wr_data,
  output logic                  frag_done,
  output logic                  blk_done,
  output logic                  xact_done,
  output logic                  cfg_err,
  output logic [ADDR_W-1:0]     dst_now
);

  localparam int FB_W  = (FRAG_LEN_W > BLK_LEN_W) ? FRAG_LEN_W : BLK_LEN_W;
  localparam int CNT_W = (XACT_LEN_W > FB_W) ? XACT_LEN_W : FB_W;

  // reset: asynchronous assertion, release aligned to clk
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  // settings check and latch
  logic [NLVL-1:0][CNT_W-1:0] len_in, len_q;
  logic                       cfg_bad, load;
  seq_state_t                 state_q, state_d;

  assign len_in[0] = CNT_W'(frag_len);
  assign len_in[1] = CNT_W'(blk_len);
  assign len_in[2] = CNT_W'(xact_len);

  hds_cfg_check #(.CNT_W(CNT_W)) i_check (
    .mode  (req_mode),
    .src_w (src_width),
    .dst_w (dst_width),
    .lens  (len_in),
    .bad   (cfg_bad)
  );

  assign load = start & (state_q == ST_IDLE) & ~cfg_bad;

  logic [1:0]        width_q;
  rq_mode_t          mode_q;
  logic [STEP_W-1:0] src_step_q, dst_step_q;
  logic              hold_src_q, hold_dst_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      width_q    <= 2'd0;
      mode_q     <= RQ_FRAG;
      src_step_q <= '0;
      dst_step_q <= '0;
      hold_src_q <= 1'b0;
      hold_dst_q <= 1'b0;
      len_q      <= '0;
    end else if (load) begin
      width_q    <= src_width;
      mode_q     <= rq_mode_t'(req_mode);
      src_step_q <= step_word[STEP_W-1:0];
      dst_step_q <= step_word[SWORD_W-1:STEP_W];
      hold_src_q <= hold_en & ~hold_sel;
      hold_dst_q <= hold_en & hold_sel;
      len_q      <= len_in;
    end
  end

  // nesting counters: each level ends on its own count or when the level above ends
  logic [2:0]      inc;
  logic            in_wr;
  logic [NLVL-1:0] lvl_end, lvl_up;

  assign inc   = elem_bytes(width_q);
  assign in_wr = (state_q == ST_WR);

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    if (g == NLVL - 1) begin : g_outer
      assign lvl_up[g] = 1'b0;
    end else begin : g_inner
      assign lvl_up[g] = lvl_end[g+1];
    end
    hds_level_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .clr     (load),
      .adv     (in_wr),
      .inc     (inc),
      .len     (len_q[g]),
      .end_in  (lvl_up[g]),
      .end_out (lvl_end[g])
    );
  end

  // address registers
  logic [ADDR_W-1:0] src_addr, dst_addr;

  hds_addr_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_src (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (load),
    .base  ({src_top, src_lo}),
    .adv   (in_wr),
    .hold  (hold_src_q),
    .step  (src_step_q),
    .addr  (src_addr)
  );

  hds_addr_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) i_dst (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (load),
    .base  ({dst_top, dst_lo}),
    .adv   (in_wr),
    .hold  (hold_dst_q),
    .step  (dst_step_q),
    .addr  (dst_addr)
  );

  // sequencing
  logic stop_here;

  always_comb begin
    case (mode_q)
      RQ_FRAG:  stop_here = lvl_end[0];
      RQ_BLOCK: stop_here = lvl_end[1];
      default:  stop_here = lvl_end[2];
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (load)  state_d = ST_RD;
      ST_RD:              state_d = ST_WR;
      ST_WR: begin
        if (lvl_end[2])     state_d = ST_IDLE;
        else if (stop_here) state_d = ST_PARK;
        else                state_d = ST_RD;
      end
      ST_PARK: if (start) state_d = ST_RD;
      default:            state_d = ST_IDLE;
    endcase
  end

  logic frag_d, blk_d, xact_d, err_d;
  logic frag_q, blk_q, xact_q, err_q;

  assign frag_d = in_wr & lvl_end[0];
  assign blk_d  = in_wr & lvl_end[1];
  assign xact_d = in_wr & lvl_end[2];
  assign err_d  = start & (state_q == ST_IDLE) & cfg_bad;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      frag_q  <= 1'b0;
      blk_q   <= 1'b0;
      xact_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      frag_q  <= frag_d;
      blk_q   <= blk_d;
      xact_q  <= xact_d;
      err_q   <= err_d;
    end
  end

  // memory port
  logic [DATA_W:0]   lane_one;
  logic [DATA_W-1:0] lane_mask;

  assign lane_one  = (DATA_W+1)'(1) << {inc, 3'b000};
  assign lane_mask = lane_one[DATA_W-1:0] - DATA_W'(1);

  assign mem_rd_en   = (state_q == ST_RD);
  assign mem_rd_addr = src_addr;
  assign mem_rd_size = width_q;
  assign mem_wr_en   = in_wr;
  assign mem_wr_addr = dst_addr;
  assign mem_wr_size = width_q;
  assign mem_wr_data = mem_rd_data & lane_mask;

  assign frag_done = frag_q;
  assign blk_done  = blk_q;
  assign xact_done = xact_q;
  assign cfg_err   = err_q;
  assign dst_now   = dst_addr;

endmodule

// File: rtl/hds_checker.sv
module hds_checker #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic              frag_done,
  input logic              blk_done,
  input logic              xact_done,
  input logic              cfg_err,
  input logic [ADDR_W-1:0] dst_now
);

  p_rd_then_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> mem_wr_en);

  p_wr_needs_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(mem_rd_en));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_done_after_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frag_done |-> $past(mem_wr_en));

  p_nesting_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xact_done |-> blk_done) and (blk_done |-> frag_done));

  p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!mem_rd_en && !mem_wr_en && !frag_done));

  p_dst_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wr_en && !start) |=> $stable(dst_now));

endmodule

bind hier_dma_seq hds_checker #(.ADDR_W(ADDR_W)) i_hds_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mem_rd_en (mem_rd_en),
  .mem_wr_en (mem_wr_en),
  .frag_done (frag_done),
  .blk_done  (blk_done),
  .xact_done (xact_done),
  .cfg_err   (cfg_err),
  .dst_now   (dst_now)
);

// File: tb/test_hier_dma_seq.sv
module test_hier_dma_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] src_lo, dst_lo, step_word;
  logic [3:0]  src_top, dst_top;
  logic [1:0]  src_width, dst_width, req_mode;
  logic        hold_en, hold_sel;
  logic [16:0] frag_len, blk_len;
  logic [27:0] xact_len;
  logic        mem_rd_en, mem_wr_en;
  logic [35:0] mem_rd_addr, mem_wr_addr, dst_now;
  logic [1:0]  mem_rd_size, mem_wr_size;
  logic [31:0] mem_rd_data, mem_wr_data;
  logic        frag_done, blk_done, xact_done, cfg_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  hier_dma_seq i_hier_dma_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_lo(src_lo), .src_top(src_top), .dst_lo(dst_lo), .dst_top(dst_top),
    .src_width(src_width), .dst_width(dst_width), .step_word(step_word),
    .hold_en(hold_en), .hold_sel(hold_sel),
    .frag_len(frag_len), .blk_len(blk_len), .xact_len(xact_len), .req_mode(req_mode),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_size(mem_rd_size),
    .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_size(mem_wr_size),
    .mem_wr_data(mem_wr_data),
    .frag_done(frag_done), .blk_done(blk_done), .xact_done(xact_done),
    .cfg_err(cfg_err), .dst_now(dst_now)
  );

  // byte memory model, read data valid the cycle after the request
  logic [7:0] mem [0:1023];
  int n_rd = 0, n_wr = 0, n_frag = 0, n_blk = 0, n_xact = 0;
  logic [35:0] last_wr_addr;
  logic [1:0]  last_wr_size;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [9:0] ix(input logic [35:0] a, input int k);
    return 10'(a[9:0] + 10'(k));
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) begin
        n_rd++;
        mem_rd_data <= {mem[ix(mem_rd_addr,3)], mem[ix(mem_rd_addr,2)],
                        mem[ix(mem_rd_addr,1)], mem[ix(mem_rd_addr,0)]};
      end
      if (mem_wr_en) begin
        n_wr++;
        last_wr_addr <= mem_wr_addr;
        last_wr_size <= mem_wr_size;
        for (int k = 0; k < (1 << mem_wr_size); k++)
          mem[ix(mem_wr_addr,k)] <= mem_wr_data[8*k +: 8];
      end
      if (frag_done) n_frag++;
      if (blk_done)  n_blk++;
      if (xact_done) n_xact++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setup(input int src, input int dst, input logic [1:0] w,
                       input logic [31:0] steps, input logic hen, input logic hsel,
                       input int fl, input int bl, input int xl, input logic [1:0] md);
    @(negedge clk);
    src_lo = 32'(src); dst_lo = 32'(dst); src_top = 4'h0; dst_top = 4'h0;
    src_width = w; dst_width = w; step_word = steps;
    hold_en = hen; hold_sel = hsel;
    frag_len = 17'(fl); blk_len = 17'(bl); xact_len = 28'(xl); req_mode = md;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_pulse(input int which, input string tag);
    bit seen = 0;
    for (int c = 0; c < 400 && !seen; c++) begin
      @(negedge clk);
      case (which)
        0: seen = frag_done;
        1: seen = blk_done;
        default: seen = xact_done;
      endcase
    end
    chk({tag, " pulse seen"}, 64'(seen), 64'd1);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic chk_copy(input string tag, input int src, input int dst, input int n);
    for (int i = 0; i < n; i++) chk(tag, mem[10'(dst + i)], pat(src + i));
  endtask

  // R1
  task automatic t_reset();
    chk("R1 rd_en", 64'(mem_rd_en), 0);
    chk("R1 wr_en", 64'(mem_wr_en), 0);
    chk("R1 pulses", 64'({frag_done, blk_done, xact_done, cfg_err}), 0);
    chk("R1 dst_now", 64'(dst_now), 0);
  endtask

  // R2 R5 R9 R10: byte copy, whole transaction
  task automatic t_bytes();
    int f0 = n_frag, b0 = n_blk, x0 = n_xact, w0 = n_wr;
    setup(32'h100, 32'h140, 2'd0, 32'h0001_0001, 0, 0, 4, 8, 16, 2'd2);
    pulse_start();
    chk("R10 fresh base visible", 64'(dst_now), 64'h140);
    wait_pulse(2, "R5 xact");
    chk_copy("R2 byte data", 32'h100, 32'h140, 16);
    chk("R2 write count", 64'(n_wr - w0), 16);
    chk("R2 write size", 64'(last_wr_size), 0);
    chk("R5 frag count", 64'(n_frag - f0), 4);
    chk("R5 blk count", 64'(n_blk - b0), 2);
    chk("R5 xact count", 64'(n_xact - x0), 1);
    chk("R9 dst_now end", 64'(dst_now), 64'h150);
  endtask

  // R2 R5 R7: word copy, block not a multiple of fragment, extra start ignored
  task automatic t_words();
    int f0 = n_frag, b0 = n_blk, x0 = n_xact, w0 = n_wr;
    setup(32'h000, 32'h080, 2'd2, 32'h0004_0004, 0, 0, 16, 24, 48, 2'd2);
    pulse_start();
    repeat (3) @(negedge clk);
    pulse_start();
    wait_pulse(2, "R5 word xact");
    chk_copy("R2 word data", 32'h000, 32'h080, 48);
    chk("R2 word size", 64'(last_wr_size), 2);
    chk("R7 busy start ignored writes", 64'(n_wr - w0), 12);
    chk("R7 busy start ignored xact", 64'(n_xact - x0), 1);
    chk("R5 short last fragment count", 64'(n_frag - f0), 4);
    chk("R5 word blk count", 64'(n_blk - b0), 2);
    chk("R9 word dst_now", 64'(dst_now), 64'h0B0);
  endtask

  // R6 R7: fragment mode then block mode, resumed by repeated starts
  task automatic t_modes();
    int f0, b0, x0, w0;
    f0 = n_frag; b0 = n_blk; x0 = n_xact; w0 = n_wr;
    setup(32'h180, 32'h1C0, 2'd1, 32'h0002_0002, 0, 0, 4, 8, 16, 2'd0);
    pulse_start();
    wait_pulse(0, "R6 frag stop");
    chk("R6 frag mode writes", 64'(n_wr - w0), 2);
    repeat (6) @(negedge clk);
    chk("R7 parked no writes", 64'(n_wr - w0), 2);
    chk("R7 parked dst held", 64'(dst_now), 64'h1C4);
    for (int k = 0; k < 3; k++) begin
      setup(32'h000, 32'h000, 2'd0, 32'h0, 0, 0, 0, 0, 0, 2'd3);
      pulse_start();
      wait_pulse(0, "R7 resume frag");
    end
    chk("R7 resume used first settings", 64'(n_wr - w0), 8);
    chk_copy("R7 resume data", 32'h180, 32'h1C0, 16);
    chk("R6 frag mode frags", 64'(n_frag - f0), 4);
    chk("R6 frag mode blks", 64'(n_blk - b0), 2);
    chk("R6 frag mode xact", 64'(n_xact - x0), 1);
    f0 = n_frag; b0 = n_blk; x0 = n_xact; w0 = n_wr;
    setup(32'h200, 32'h220, 2'd1, 32'h0002_0002, 0, 0, 4, 8, 16, 2'd1);
    pulse_start();
    wait_pulse(1, "R6 block stop");
    chk("R6 block mode writes", 64'(n_wr - w0), 4);
    chk("R6 block mode no xact", 64'(n_xact - x0), 0);
    pulse_start();
    wait_pulse(2, "R6 block mode end");
    chk("R6 block mode frags", 64'(n_frag - f0), 4);
    chk("R6 block mode total writes", 64'(n_wr - w0), 8);
  endtask

  // R4
  task automatic t_hold();
    setup(32'h300, 32'h380, 2'd0, 32'h0001_0001, 1, 1, 4, 4, 4, 2'd2);
    pulse_start();
    wait_pulse(2, "R4 dst hold");
    chk("R4 dst held addr", 64'(dst_now), 64'h380);
    chk("R4 dst held data", 64'(mem[10'h380]), 64'(pat(32'h303)));
    setup(32'h310, 32'h3C0, 2'd0, 32'h0001_0001, 1, 0, 4, 4, 4, 2'd2);
    pulse_start();
    wait_pulse(2, "R4 src hold");
    for (int i = 0; i < 4; i++)
      chk("R4 src held data", 64'(mem[10'(32'h3C0 + i)]), 64'(pat(32'h310)));
    chk("R4 src hold dst moves", 64'(dst_now), 64'h3C4);
  endtask

  // R3
  task automatic t_high();
    setup(32'h260, 32'h240, 2'd0, 32'h0003_0001, 0, 0, 2, 2, 2, 2'd2);
    dst_top = 4'hA;
    pulse_start();
    wait_pulse(2, "R3 xact");
    chk("R3 last write addr", 64'(last_wr_addr), 64'hA_0000_0243);
    chk("R3 dst_now with top bits", 64'(dst_now), 64'hA_0000_0246);
    chk("R3 data at stepped dst", 64'(mem[10'h243]), 64'(pat(32'h261)));
  endtask

  // R8
  task automatic err_case(input string tag);
    int r0 = n_rd, w0 = n_wr;
    pulse_start();
    chk({"R8 err pulse ", tag}, 64'(cfg_err), 1);
    repeat (6) @(negedge clk);
    chk({"R8 no reads ", tag}, 64'(n_rd - r0), 0);
    chk({"R8 no writes ", tag}, 64'(n_wr - w0), 0);
  endtask

  task automatic t_errors();
    setup(32'h000, 32'h3E0, 2'd0, 32'h0001_0001, 0, 0, 4, 4, 4, 2'd3);
    err_case("mode3");
    setup(32'h000, 32'h3E0, 2'd3, 32'h0001_0001, 0, 0, 4, 4, 4, 2'd2);
    err_case("width3");
    setup(32'h000, 32'h3E0, 2'd0, 32'h0001_0001, 0, 0, 4, 4, 4, 2'd2);
    dst_width = 2'd1;
    err_case("width mismatch");
    setup(32'h000, 32'h3E0, 2'd0, 32'h0001_0001, 0, 0, 0, 4, 4, 2'd2);
    err_case("zero length");
    setup(32'h000, 32'h3E0, 2'd2, 32'h0004_0004, 0, 0, 4, 6, 8, 2'd2);
    err_case("misaligned");
    chk("R8 dst_now unchanged", 64'(dst_now), 64'hA_0000_0246);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
    mem_rd_data = '0;
    rst_n = 1'b0; start = 1'b0;
    src_lo = '0; dst_lo = '0; src_top = '0; dst_top = '0;
    src_width = '0; dst_width = '0; step_word = '0; hold_en = 0; hold_sel = 0;
    frag_len = '0; blk_len = '0; xact_len = '0; req_mode = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bytes();
    t_words();
    t_modes();
    t_hold();
    t_high();
    t_errors();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule